// File: doc/BRIEF.md
# Cascadable Signed Multiplier Input Array

This block holds eight signed 18x18 multipliers in two groups of four. Each multiplier has its own registered A and B operand. An elaboration-time parameter decides where every A register loads from. In parallel mode each lane loads from its own slice of the A bus. In cascade mode the eight A registers form one tap-delay line, fed from a chain input and shifting one lane per enabled clock. The line crosses from the upper group into the lower one. Its last tap leaves the block so that another instance can continue the line.

The B registers always load from their own input slices, with one exception. The first lane of each group can instead load the upper 18 bits of that group's registered result. This gives a recursive filter its previous output without routing outside the block. Each group sums its four 36-bit products into a registered 38-bit result.

All registers share one clock, an active-low asynchronous reset that clears them, and a clock enable. Operands reach the result two enabled edges after they are presented.

Top module: `tap_mult_array`

## Requirements
- R1: While rst_ni is low, every operand register and every result register is zero, so res_o and chain_o read zero.
- R2: With CASCADE=0, lane k's A register loads a_i[18k+17:18k] on each enabled edge. The result of group h (res_o[38h+37:38h], lanes 4h..4h+3) then equals the signed sum of that group's four A*B products one enabled edge later, which is two enabled edges after the operands were presented.
- R3: While en_i is low, all A, B and result registers hold their values, including the tap-delay line and chain_o.
- R4: With CASCADE=1, lane 0 loads chain_i on each enabled edge, and every other lane loads the previous A value of the lane above it. a_i has no effect on the results.
- R5: With CASCADE=1, the first lane of the lower group (lane 4) loads the previous A value of the last lane of the upper group (lane 3).
- R6: chain_o is the A register of lane 7. With CASCADE=1, a value on chain_i appears on chain_o after eight enabled edges.
- R7: When fb_sel_i[h] is high at an enabled edge, the B register of lane 4h loads bits [37:20] of group h's current result instead of its b_i slice.
- R8: Lanes other than the first of each group always load B from their own b_i slice. The first lane also does so when its fb_sel_i bit is low.
- R9: Products and sums are fully signed over the whole 18-bit range. The 38-bit result never wraps, including when all four products are (-2^17)*(-2^17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for every register |
| a_i | input | 144 | A operands, lane k at bits [18k+17:18k] |
| b_i | input | 144 | B operands, lane k at bits [18k+17:18k] |
| chain_i | input | 18 | Tap-delay line input into lane 0 (cascade mode) |
| fb_sel_i | input | 2 | Per group, selects the result loopback into the first lane's B register |
| chain_o | output | 18 | Lane 7 A register, for extending the delay line |
| res_o | output | 76 | Registered group sums, group h at bits [38h+37:38h] |

## Verification
The bound checker watches every cycle for the register-to-register relations. These are the A capture in parallel mode, the lane-to-lane shift and the crossing between groups, chain_o following lane 6, B loading either its direct input or the loopback bits, and everything frozen while the enable is low.

The arithmetic itself is shown only by the bench's scenarios. These are the signed sums at the range extremes, the exact two-edge latency, the impulse walking through eight taps with distinct weights per lane, and the rounding-down of a negative result when its upper bits are fed back.

// File: rtl/tap_mult_pkg.sv
package tap_mult_pkg;
  localparam int OP_W_DEF    = 18;
  localparam int LANES_DEF   = 4;
  localparam int HALVES_DEF  = 2;

  function automatic int sum_width(input int op_w, input int lanes);
    return 2 * op_w + $clog2(lanes);
  endfunction
endpackage

// File: rtl/tap_mult_a_stage.sv
module tap_mult_a_stage #(
  parameter int W       = 18,
  parameter bit CASCADE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] par_i,
  input  logic [W-1:0] shift_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  // source fixed at elaboration
  assign d = CASCADE ? shift_i : par_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d;
  end
endmodule

// File: rtl/tap_mult_b_stage.sv
module tap_mult_b_stage #(
  parameter int W    = 18,
  parameter bit LOOP = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] direct_i,
  input  logic [W-1:0] loop_i,
  input  logic         loop_sel_i,
  output logic [W-1:0] q_o
);
  logic         sel;
  logic [W-1:0] d;

  // only lanes built with LOOP get a real mux
  assign sel = LOOP & loop_sel_i;
  assign d   = sel ? loop_i : direct_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d;
  end
endmodule

// File: rtl/tap_mult_half.sv
module tap_mult_half #(
  parameter int OP_W  = 18,
  parameter int LANES = 4,
  parameter int RES_W = 38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [OP_W-1:0]  a_i [LANES],
  input  logic [OP_W-1:0]  b_i [LANES],
  output logic [RES_W-1:0] res_o,
  output logic [OP_W-1:0]  fb_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = RES_W - PROD_W;

  logic signed [PROD_W-1:0] prod [LANES];
  logic signed [RES_W-1:0]  sum_c;
  logic        [RES_W-1:0]  res_q;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    assign prod[i] = $signed(a_i[i]) * $signed(b_i[i]);
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < LANES; i++) begin
      sum_c = sum_c + $signed({{EXT_W{prod[i][PROD_W-1]}}, prod[i]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (en_i) res_q <= sum_c;
  end

  assign res_o = res_q;
  assign fb_o  = res_q[RES_W-1 -: OP_W];
endmodule

// File: rtl/tap_mult_array.sv
module tap_mult_array
  import tap_mult_pkg::*;
#(
  parameter int OP_W    = OP_W_DEF,
  parameter int LANES   = LANES_DEF,
  parameter int HALVES  = HALVES_DEF,
  parameter bit CASCADE = 1'b0,
  localparam int N_TOT  = LANES * HALVES,
  localparam int RES_W  = sum_width(OP_W, LANES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [N_TOT*OP_W-1:0]   a_i,
  input  logic [N_TOT*OP_W-1:0]   b_i,
  input  logic [OP_W-1:0]         chain_i,
  input  logic [HALVES-1:0]       fb_sel_i,
  output logic [OP_W-1:0]         chain_o,
  output logic [HALVES*RES_W-1:0] res_o
);
  logic [OP_W-1:0] a_q [N_TOT];
  logic [OP_W-1:0] b_q [N_TOT];
  logic [OP_W-1:0] fb  [HALVES];

  for (genvar g = 0; g < N_TOT; g++) begin : g_lane
    localparam int  H     = g / LANES;
    localparam bit  FIRST = (g % LANES) == 0;
    logic [OP_W-1:0] shift_src;

    // chain runs lane 0 -> lane N_TOT-1, across group boundaries
    if (g == 0) begin : g_head
      assign shift_src = chain_i;
    end else begin : g_link
      assign shift_src = a_q[g-1];
    end

    tap_mult_a_stage #(.W(OP_W), .CASCADE(CASCADE)) u_a (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .par_i   (a_i[g*OP_W +: OP_W]),
      .shift_i (shift_src),
      .q_o     (a_q[g])
    );

    tap_mult_b_stage #(.W(OP_W), .LOOP(FIRST)) u_b (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .direct_i   (b_i[g*OP_W +: OP_W]),
      .loop_i     (fb[H]),
      .loop_sel_i (fb_sel_i[H]),
      .q_o        (b_q[g])
    );
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [OP_W-1:0]  ha [LANES];
    logic [OP_W-1:0]  hb [LANES];
    logic [RES_W-1:0] hres;

    for (genvar i = 0; i < LANES; i++) begin : g_map
      assign ha[i] = a_q[h*LANES+i];
      assign hb[i] = b_q[h*LANES+i];
    end

    tap_mult_half #(.OP_W(OP_W), .LANES(LANES), .RES_W(RES_W)) u_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .a_i    (ha),
      .b_i    (hb),
      .res_o  (hres),
      .fb_o   (fb[h])
    );

    assign res_o[h*RES_W +: RES_W] = hres;
  end

  assign chain_o = a_q[N_TOT-1];
endmodule

// File: rtl/tap_mult_array_chk.sv
module tap_mult_array_chk #(
  parameter int OP_W    = 18,
  parameter int LANES   = 4,
  parameter int HALVES  = 2,
  parameter bit CASCADE = 1'b0,
  parameter int RES_W   = 38,
  localparam int N_TOT  = LANES * HALVES
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [N_TOT*OP_W-1:0]   a_i,
  input logic [N_TOT*OP_W-1:0]   b_i,
  input logic [OP_W-1:0]         chain_i,
  input logic [HALVES-1:0]       fb_sel_i,
  input logic [OP_W-1:0]         chain_o,
  input logic [HALVES*RES_W-1:0] res_o,
  input logic [OP_W-1:0]         a_q [N_TOT],
  input logic [OP_W-1:0]         b_q [N_TOT]
);
  logic pv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv <= 1'b0;
    else         pv <= 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && !$past(en_i) |-> $stable(res_o) && $stable(chain_o));

  assert_chain_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(en_i) |-> (!CASCADE || chain_o == $past(a_q[N_TOT-2])));

  for (genvar g = 0; g < N_TOT; g++) begin : g_lane
    localparam int H = g / LANES;

    assert_a_par_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pv && $past(en_i) |-> (CASCADE || a_q[g] == $past(a_i[g*OP_W +: OP_W])));

    assert_lane_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pv && !$past(en_i) |-> $stable(a_q[g]) && $stable(b_q[g]));

    if (g == 0) begin : g_head
      assert_shift_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) |-> (!CASCADE || a_q[0] == $past(chain_i)));
    end else if ((g % LANES) == 0) begin : g_cross
      assert_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) |-> (!CASCADE || a_q[g] == $past(a_q[g-1])));
    end else begin : g_inner
      assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) |-> (!CASCADE || a_q[g] == $past(a_q[g-1])));
    end

    if ((g % LANES) == 0) begin : g_first
      assert_loop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) && $past(fb_sel_i[H]) |->
          b_q[g] == $past(res_o[H*RES_W+RES_W-1 -: OP_W]));
      assert_b_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) && !$past(fb_sel_i[H]) |->
          b_q[g] == $past(b_i[g*OP_W +: OP_W]));
    end else begin : g_rest
      assert_b_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pv && $past(en_i) |-> b_q[g] == $past(b_i[g*OP_W +: OP_W]));
    end
  end
endmodule

bind tap_mult_array tap_mult_array_chk #(
  .OP_W    (OP_W),
  .LANES   (LANES),
  .HALVES  (HALVES),
  .CASCADE (CASCADE),
  .RES_W   (RES_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .chain_i  (chain_i),
  .fb_sel_i (fb_sel_i),
  .chain_o  (chain_o),
  .res_o    (res_o),
  .a_q      (a_q),
  .b_q      (b_q)
);

// File: tb/tap_mult_array_tb_top.sv
module tap_mult_array_tb_top;
  localparam int W  = 18;
  localparam int L  = 4;
  localparam int H  = 2;
  localparam int N  = L * H;
  localparam int RW = 38;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           en_i = 1'b0;
  logic [N*W-1:0] a_i = '0;
  logic [N*W-1:0] b_i = '0;
  logic [W-1:0]   chain_i = '0;
  logic [H-1:0]   fb_sel_i = '0;
  logic [W-1:0]   chain_c, chain_p;
  logic [H*RW-1:0] res_c, res_p;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tap_mult_array #(.CASCADE(1'b1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .a_i(a_i), .b_i(b_i),
    .chain_i(chain_i), .fb_sel_i(fb_sel_i), .chain_o(chain_c), .res_o(res_c));

  tap_mult_array #(.CASCADE(1'b0)) dut_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .a_i(a_i), .b_i(b_i),
    .chain_i(chain_i), .fb_sel_i(fb_sel_i), .chain_o(chain_p), .res_o(res_p));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint grp(input logic [H*RW-1:0] r, input int h);
    logic signed [RW-1:0] s;
    s = r[h*RW +: RW];
    return longint'(s);
  endfunction

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_lane(input int k, input longint av, input longint bv);
    a_i[k*W +: W] = av[W-1:0];
    b_i[k*W +: W] = bv[W-1:0];
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; en_i = 1'b0; a_i = '0; b_i = '0; chain_i = '0; fb_sel_i = '0;
    tick; tick;
    a_i = '1; b_i = '1; chain_i = '1; en_i = 1'b1;
    tick;
    // R1: reset dominates enable and data
    check("R1 res_c g0", grp(res_c, 0), 0);
    check("R1 res_p g1", grp(res_p, 1), 0);
    check("R1 chain_c", sx(chain_c), 0);
    check("R1 chain_p", sx(chain_p), 0);
    en_i = 1'b0; a_i = '0; b_i = '0; chain_i = '0;
    rst_ni = 1'b1;
    tick;
  endtask

  task automatic t_parallel(input int mode, input string tag);
    longint exp [H];
    longint av, bv;
    for (int h = 0; h < H; h++) exp[h] = 0;
    for (int k = 0; k < N; k++) begin
      case (mode)
        0: begin av = (k * 7919 + 123) % 65536 - 32768; bv = 1000 - k * 377; end
        1: begin av = -131072; bv = -131072; end
        default: begin av = -131072; bv = 131071; end
      endcase
      set_lane(k, av, bv);
      exp[k / L] += av * bv;
    end
    fb_sel_i = '0; en_i = 1'b1;
    tick;
    tick;
    for (int h = 0; h < H; h++) check(tag, grp(res_p, h), exp[h]);
  endtask

  task automatic t_cascade;
    longint v, e;
    do_reset;
    v = -1000;
    for (int k = 0; k < N; k++) set_lane(k, 5000 + k, k + 1);
    fb_sel_i = '0; en_i = 1'b1;
    chain_i = v[W-1:0];
    tick;
    chain_i = '0;
    for (int n = 1; n <= 10; n++) begin
      if (n > 1) begin
        a_i = ~a_i;   // a_i must not matter (R4)
        for (int k = 0; k < N; k++) b_i[k*W +: W] = W'(k + 1);
        tick;
      end
      for (int h = 0; h < H; h++) begin
        e = (n >= 2 && n <= 9 && (n - 2) / L == h) ? v * (n - 1) : 0;
        check(h == 0 ? "R4 tap walk g0" : "R5 tap walk g1", grp(res_c, h), e);
      end
      check("R6 chain_o", sx(chain_c), (n == 8) ? v : 0);
    end
  endtask

  task automatic t_hold;
    longint r0, r1, p0, p1;
    en_i = 1'b1;
    chain_i = W'(77);
    for (int i = 0; i < 9; i++) tick;
    check("R6 chain_o steady", sx(chain_c), 77);
    r0 = grp(res_c, 0); r1 = grp(res_c, 1);
    p0 = grp(res_p, 0); p1 = grp(res_p, 1);
    en_i = 1'b0;
    chain_i = W'(5); a_i = ~a_i; b_i = ~b_i; fb_sel_i = '1;
    tick; tick; tick;
    check("R3 chain hold", sx(chain_c), 77);
    check("R3 res_c g0 hold", grp(res_c, 0), r0);
    check("R3 res_c g1 hold", grp(res_c, 1), r1);
    check("R3 res_p g0 hold", grp(res_p, 0), p0);
    check("R3 res_p g1 hold", grp(res_p, 1), p1);
    fb_sel_i = '0;
  endtask

  task automatic t_loop(input longint sgn, input int hh);
    longint big, fbv, oth;
    int base, obase;
    do_reset;
    base = hh * L; obase = (1 - hh) * L;
    big = sgn * 40000 * 30000;
    fbv = big >>> 20;
    set_lane(base, sgn * 40000, 30000);
    set_lane(obase, 5, 7);
    fb_sel_i = '0; en_i = 1'b1;
    tick; tick;
    check("R2 loop seed", grp(res_p, hh), big);
    fb_sel_i[hh] = 1'b1;
    set_lane(base, 3, 999);
    set_lane(base + 1, 2, 11);
    tick;
    check("R7 result pre-loop", grp(res_p, hh), big);
    tick;
    check("R7 loopback product", grp(res_p, hh), 3 * fbv + 22);
    oth = 35;
    check("R8 other group direct", grp(res_p, 1 - hh), oth);
    fb_sel_i = '0;
    tick; tick;
    check("R8 first lane direct again", grp(res_p, hh), 3 * 999 + 22);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset;
    t_parallel(0, "R2 mixed operands");
    t_parallel(1, "R9 max positive sum");
    t_parallel(2, "R9 max negative sum");
    t_cascade;
    t_hold;
    t_loop(1, 0);
    t_loop(-1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule